// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block merges a 32-bit top-level source vector and a 32-bit second-level peripheral vector onto a single CPU interrupt line. Selected top-level positions are rising-edge sources caught in a hardware latch, and the rest are level sources. Three top-level positions are not taken from the top-level inputs. Each of them summarises one group of masked second-level sources. Some second-level positions are latched on their rising edge as well.

Each cycle the controller ANDs the top-level status with its enable mask and picks the lowest set bit. It registers the CPU line, a 1-based vector number and a valid flag. When the winning bit is a summary bit, the vector resolves through the cascade to 32 plus the 1-based index of the lowest masked second-level source.

Software uses a small register port with single-cycle writes and registered reads. Through it, software sets both masks, reads both status vectors and clears latched edges.

Top module: `cirq_ctrl`

## Requirements
- R1: After reset the top mask, the second-level mask, the top hardware latch and the second-level edge latches are zero, and irq_o, vec_valid_o, vec_o and reg_rdata_o are 0.
- R2: Top-level bits 16-19, 22-24 and 28-30 are set on a rising edge of their input, where an edge means the input is 1 now and was 0 in the previous cycle, and the previous-cycle sample resets to 0. These bits stay set after the input falls until software clears them by writing 0 to that bit of the hardware latch register (address 2).
- R3: Writing 1 to a hardware latch bit never sets or clears it. A rising edge in the same cycle as a clearing write wins, and the bit stays set.
- R4: All other top-level bits except 4-6 are level sources. This includes bits 25-27. They follow their inputs with no latching.
- R5: Top-level status bit 6 is the OR of masked second-level bits 0-7. Bit 5 is the OR of masked bits 8-15, and bit 4 is the OR of masked bits 16-31. The top-level inputs on bits 4-6 are ignored.
- R6: The winning source is the lowest set bit of top status AND top mask. For a non-summary bit n, vec_o = n+1.
- R7: When the winner is bit 4, 5 or 6, vec_o = 32 + 1 + the index of the lowest set bit of second-level status AND second-level mask.
- R8: Second-level bits 16, 22 and 28 latch on a rising edge and are cleared by writing 0 to that bit of the second-level status register (address 4). Edge beats clear in the same cycle. All other second-level bits follow their inputs.
- R9: irq_o is 1 exactly when a masked top-level bit was set in the previous clock cycle. The output is registered and changes one cycle after its inputs.
- R10: With no enabled source pending, vec_valid_o is 0 and vec_o is 0. Otherwise vec_valid_o is 1.
- R11: The port has these addresses: 0 top mask (read/write), 1 top status (read-only; writes are ignored), 2 hardware latch, 3 second-level mask (read/write) and 4 second-level status. Other addresses read as 0. reg_rdata_o shows the addressed value one cycle after the address is presented, and a write takes effect at the clock edge where reg_we_i is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| top_src_i | input | 32 | Top-level synchronous source inputs (bits 4-6 ignored) |
| sub_src_i | input | 32 | Second-level synchronous source inputs |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | CPU interrupt line |
| vec_o | output | 7 | 1-based vector of the winning source, 0 when idle |
| vec_valid_o | output | 1 | Vector is valid |

## Verification
The bench builds the block with its default 32-bit top and second-level widths and fixed edge and summary positions. That width reaches the largest cascaded vector numbers, up to 64, and every edge-capable position in both levels. A behavioural model predicts the outputs and read data on every clock. Directed sequences cover edges that collide with clearing writes, summary bits that pre-empt lower-priority level sources, and cascade resolution when the lowest second-level bit lies outside the group that won at the top level.

// File: rtl/cirq_pkg.sv
package cirq_pkg;
  localparam int TOP_W   = 32;
  localparam int SUB_W   = 32;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 3;
  localparam int SUB_OFS = 32;
  localparam int VEC_W   = $clog2(TOP_W + SUB_W + 1);

  // edge-captured positions
  localparam logic [TOP_W-1:0] TOP_EDGE = 32'h71CF_0000;
  localparam logic [SUB_W-1:0] SUB_EDGE = 32'h1041_0000;

  // summary positions in top-level status
  localparam int SUM_HI  = 4;  // second-level 16..31
  localparam int SUM_MID = 5;  // second-level 8..15
  localparam int SUM_LO  = 6;  // second-level 0..7

  typedef enum logic [ADDR_W-1:0] {
    A_TMASK = 3'd0,
    A_TSTAT = 3'd1,
    A_HWLAT = 3'd2,
    A_SMASK = 3'd3,
    A_SSTAT = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/cirq_edge_latch.sv
module cirq_edge_latch #(
  parameter int           W    = 32,
  parameter logic [W-1:0] EDGE = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_data_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] latch_o
);
  logic [W-1:0] src_q, lat_q, rise;

  assign rise    = src_i & ~src_q & EDGE;
  assign stat_o  = (src_i & ~EDGE) | lat_q | rise;
  assign latch_o = lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0;
      lat_q <= '0;
    end else begin
      src_q <= src_i;
      lat_q <= ((clr_we_i ? (lat_q & clr_data_i) : lat_q) | rise) & EDGE;
    end
  end

  // R2 / R8: latched bits only drop on a clearing write
  assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_we_i |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R3 / R8: an edge colliding with a clear survives
  assert_edge_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && (|(src_i & ~src_q & EDGE)))
      |=> ((lat_q & $past(src_i & ~src_q & EDGE)) == $past(src_i & ~src_q & EDGE)));
endmodule

// File: rtl/cirq_lowest.sv
module cirq_lowest #(
  parameter int W     = 32,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     req_i,
  output logic             found_o,
  output logic [IDX_W-1:0] idx_o
);
  assign found_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

  always_comb begin
    if (found_o) begin
      assert_lowest_R6: assert (req_i[idx_o] &&
        ((req_i & ((W'(1) << idx_o) - W'(1))) == '0))
        else $error("lowest-bit encoder mismatch");
    end
  end
endmodule

// File: rtl/cirq_regs.sv
module cirq_regs
  import cirq_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] top_stat_i,
  input  logic [DW-1:0] hw_lat_i,
  input  logic [DW-1:0] sub_stat_i,
  output logic [DW-1:0] top_mask_o,
  output logic [DW-1:0] sub_mask_o,
  output logic          hw_we_o,
  output logic          sub_we_o,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] rd_mux;

  assign hw_we_o  = we_i && (addr_i == AW'(A_HWLAT));
  assign sub_we_o = we_i && (addr_i == AW'(A_SSTAT));

  always_comb begin
    case (addr_i)
      AW'(A_TMASK): rd_mux = top_mask_o;
      AW'(A_TSTAT): rd_mux = top_stat_i;
      AW'(A_HWLAT): rd_mux = hw_lat_i;
      AW'(A_SMASK): rd_mux = sub_mask_o;
      AW'(A_SSTAT): rd_mux = sub_stat_i;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_mask_o <= '0;
      sub_mask_o <= '0;
      rdata_o    <= '0;
    end else begin
      if (we_i && addr_i == AW'(A_TMASK)) top_mask_o <= wdata_i;
      if (we_i && addr_i == AW'(A_SMASK)) sub_mask_o <= wdata_i;
      rdata_o <= rd_mux;
    end
  end

  // R11: status address is read-only
  assert_stat_ro_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(A_TSTAT)) |=> ($stable(top_mask_o) && $stable(sub_mask_o)));
endmodule

// File: rtl/cirq_ctrl.sv
module cirq_ctrl
  import cirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TOP_W-1:0]  top_src_i,
  input  logic [SUB_W-1:0]  sub_src_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  localparam int TIDX_W = $clog2(TOP_W);
  localparam int SIDX_W = $clog2(SUB_W);
  localparam logic [TOP_W-1:0] SUM_MASK =
    (TOP_W'(1) << SUM_HI) | (TOP_W'(1) << SUM_MID) | (TOP_W'(1) << SUM_LO);

  logic [TOP_W-1:0]  top_raw, top_lat, top_stat, top_mask, top_pend;
  logic [SUB_W-1:0]  sub_stat, sub_lat, sub_mask, sub_pend;
  logic              hw_we, sub_we;
  logic              t_found, s_found, is_sum;
  logic [TIDX_W-1:0] t_idx;
  logic [SIDX_W-1:0] s_idx;
  logic [VEC_W-1:0]  vec_d;
  logic [2:0]        sum_bits;

  cirq_edge_latch #(.W(TOP_W), .EDGE(TOP_EDGE)) u_top_lat (
    .clk_i, .rst_ni,
    .src_i      (top_src_i),
    .clr_we_i   (hw_we),
    .clr_data_i (reg_wdata_i),
    .stat_o     (top_raw),
    .latch_o    (top_lat)
  );

  cirq_edge_latch #(.W(SUB_W), .EDGE(SUB_EDGE)) u_sub_lat (
    .clk_i, .rst_ni,
    .src_i      (sub_src_i),
    .clr_we_i   (sub_we),
    .clr_data_i (reg_wdata_i),
    .stat_o     (sub_stat),
    .latch_o    (sub_lat)
  );

  cirq_regs u_regs (
    .clk_i, .rst_ni,
    .addr_i     (reg_addr_i),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .top_stat_i (top_stat),
    .hw_lat_i   (top_lat),
    .sub_stat_i (sub_stat),
    .top_mask_o (top_mask),
    .sub_mask_o (sub_mask),
    .hw_we_o    (hw_we),
    .sub_we_o   (sub_we),
    .rdata_o    (reg_rdata_o)
  );

  // summary folding
  assign sub_pend = sub_stat & sub_mask;
  assign sum_bits = {|sub_pend[7:0], |sub_pend[15:8], |sub_pend[31:16]};

  always_comb begin
    top_stat = top_raw & ~SUM_MASK;
    top_stat[SUM_LO]  = sum_bits[2];
    top_stat[SUM_MID] = sum_bits[1];
    top_stat[SUM_HI]  = sum_bits[0];
  end

  assign top_pend = top_stat & top_mask;

  cirq_lowest #(.W(TOP_W)) u_top_enc (
    .req_i (top_pend), .found_o (t_found), .idx_o (t_idx)
  );

  cirq_lowest #(.W(SUB_W)) u_sub_enc (
    .req_i (sub_pend), .found_o (s_found), .idx_o (s_idx)
  );

  assign is_sum = t_found && SUM_MASK[t_idx];

  always_comb begin
    if (!t_found)    vec_d = '0;
    else if (is_sum) vec_d = VEC_W'(SUB_OFS) + VEC_W'(s_idx) + VEC_W'(1);
    else             vec_d = VEC_W'(t_idx) + VEC_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      irq_o       <= t_found;
      vec_o       <= vec_d;
      vec_valid_o <= t_found;
    end
  end

  assert_irq_lag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(top_stat & top_mask))));

  assert_idle_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vec_valid_o |-> (vec_o == '0));

  assert_cascade_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_valid_o && vec_o > VEC_W'(SUB_OFS)) |-> $past(|(top_pend & SUM_MASK) && s_found));

  assert_vec_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_o != '0 && vec_o <= VEC_W'(TOP_W + SUB_W)));
endmodule

// File: tb/sim_cirq_ctrl.sv
module sim_cirq_ctrl;
  localparam int CLK_P = 10;
  localparam logic [31:0] TE = 32'h71CF_0000;
  localparam logic [31:0] SE = 32'h1041_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tsrc = '0, ssrc = '0, wdata = '0;
  logic [2:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        irq, vvalid;
  logic [6:0]  vec;

  always #(CLK_P/2) clk = ~clk;

  cirq_ctrl u0 (
    .clk_i (clk), .rst_ni (rst_n),
    .top_src_i (tsrc), .sub_src_i (ssrc),
    .reg_addr_i (addr), .reg_we_i (we), .reg_wdata_i (wdata),
    .reg_rdata_o (rdata), .irq_o (irq), .vec_o (vec), .vec_valid_o (vvalid)
  );

  int    n_chk = 0, n_bad = 0;
  bit    chk_en = 1'b0;
  string cur_req = "R1";

  // reference model state
  logic [31:0] m_tmask = '0, m_smask = '0, m_hw = '0, m_shw = '0;
  logic [31:0] m_tprev = '0, m_sprev = '0;
  logic        e_irq = 1'b0, e_valid = 1'b0;
  int          e_vec = 0;
  logic [31:0] e_rdata = '0;

  function automatic logic [31:0] bit_of(int i);
    return 32'h1 << i;
  endfunction

  function automatic int lowest(logic [31:0] v);
    int lo = -1;
    for (int i = 31; i >= 0; i--) if (v[i]) lo = i;
    return lo;
  endfunction

  always @(posedge clk) begin : model
    logic [31:0] trise, srise, tstat, sstat, spend, tpend;
    int lo;
    if (!rst_n) begin
      m_tmask = '0; m_smask = '0; m_hw = '0; m_shw = '0;
      m_tprev = '0; m_sprev = '0;
      e_irq = 0; e_valid = 0; e_vec = 0; e_rdata = '0;
    end else begin
      trise = tsrc & ~m_tprev & TE;
      srise = ssrc & ~m_sprev & SE;
      sstat = (ssrc & ~SE) | m_shw | srise;
      spend = sstat & m_smask;
      tstat = ((tsrc & ~TE) | m_hw | trise) & ~32'h70;
      tstat[6] = |spend[7:0];
      tstat[5] = |spend[15:8];
      tstat[4] = |spend[31:16];
      tpend = tstat & m_tmask;
      lo = lowest(tpend);
      e_irq = (lo >= 0);
      e_valid = (lo >= 0);
      if (lo < 0) e_vec = 0;
      else if (lo >= 4 && lo <= 6) e_vec = 33 + lowest(spend);
      else e_vec = lo + 1;
      case (addr)
        3'd0: e_rdata = m_tmask;
        3'd1: e_rdata = tstat;
        3'd2: e_rdata = m_hw;
        3'd3: e_rdata = m_smask;
        3'd4: e_rdata = sstat;
        default: e_rdata = '0;
      endcase
      if (we && addr == 3'd2) m_hw = m_hw & wdata;
      if (we && addr == 3'd4) m_shw = m_shw & wdata;
      m_hw  = (m_hw | trise) & TE;
      m_shw = (m_shw | srise) & SE;
      if (we && addr == 3'd0) m_tmask = wdata;
      if (we && addr == 3'd3) m_smask = wdata;
      m_tprev = tsrc;
      m_sprev = ssrc;
    end
  end

  task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_en) begin
      cmp("irq_o", 32'(irq), 32'(e_irq));
      cmp("vec_o", 32'(vec), 32'(e_vec));
      cmp("vec_valid_o", 32'(vvalid), 32'(e_valid));
      cmp("reg_rdata_o", rdata, e_rdata);
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick();
    we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    addr = a;
    tick();
    d = rdata;
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1 act=hung exp=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : stim
    logic [31:0] d;
    tick(); tick(); tick();
    chk("R1", "irq in reset", 32'(irq), 0);
    chk("R1", "vec in reset", 32'(vec), 0);
    chk_en = 1'b1;
    rst_n = 1'b1;
    tick();
    // R1: registers clear after reset
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk("R1", "reset read", d, 0);
    end

    cur_req = "R11";
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R11", "top mask readback", d, 32'hFFFF_FFFF);

    // R4 / R6 / R9: level source 7
    cur_req = "R4";
    tsrc = bit_of(7); tick();
    chk("R9", "irq one cycle after source", 32'(irq), 1);
    chk("R6", "vec bit7", 32'(vec), 8);
    tsrc = '0; tick();
    chk("R10", "idle vec", 32'(vec), 0);
    chk("R10", "idle valid", 32'(vvalid), 0);
    tsrc = bit_of(25); tick();
    chk("R4", "level bit25", 32'(vec), 26);
    tsrc = '0; tick();
    chk("R4", "level bit25 follows input", 32'(vec), 0);

    // R2: edge source 16 latched
    cur_req = "R2";
    tsrc = bit_of(16); tick();
    tsrc = '0;
    chk("R2", "edge bit16", 32'(vec), 17);
    tick();
    chk("R2", "edge bit16 held", 32'(vec), 17);
    rd(3'd2, d); chk("R2", "latch readback", d, 32'h0001_0000);
    cur_req = "R3";
    wr(3'd2, 32'hFFFF_FFFF); tick();
    chk("R3", "write ones keeps latch", 32'(vec), 17);
    rd(3'd2, d); chk("R3", "write ones no set", d, 32'h0001_0000);
    cur_req = "R2";
    wr(3'd2, 32'h0); tick();
    chk("R2", "latch cleared", 32'(vec), 0);

    // R3: edge wins over clear
    cur_req = "R3";
    tsrc = bit_of(22); addr = 3'd2; wdata = '0; we = 1'b1;
    tick();
    we = 1'b0; tsrc = '0;
    tick();
    chk("R3", "edge beats clear", 32'(vec), 23);
    wr(3'd2, 32'h0); tick();
    chk("R3", "cleared after", 32'(vec), 0);

    // R6: priority and mask
    cur_req = "R6";
    tsrc = bit_of(10) | bit_of(20); tick();
    chk("R6", "lowest wins", 32'(vec), 11);
    wr(3'd0, ~bit_of(10)); tick();
    chk("R6", "masked bit skipped", 32'(vec), 21);
    wr(3'd0, 32'hFFFF_FFFF);
    tsrc = '0; tick();

    // R5: top inputs 4..6 ignored
    cur_req = "R5";
    tsrc = 32'h70; tick(); tick();
    chk("R5", "summary inputs ignored", 32'(irq), 0);
    tsrc = '0;

    // R7 / R5: cascade
    cur_req = "R7";
    ssrc = bit_of(3); tick();
    chk("R7", "sub bit3", 32'(vec), 36);
    rd(3'd1, d); chk("R5", "top status bit6", d, 32'h40);
    ssrc = bit_of(9); tick();
    chk("R7", "sub bit9", 32'(vec), 42);
    ssrc = bit_of(20); tick();
    chk("R7", "sub bit20", 32'(vec), 53);
    ssrc = bit_of(3) | bit_of(20); tick();
    chk("R7", "summary bit4 wins, lowest sub", 32'(vec), 36);
    tsrc = bit_of(2); tick();
    chk("R6", "top bit2 beats summary", 32'(vec), 3);
    tsrc = '0; ssrc = bit_of(3);
    cur_req = "R5";
    wr(3'd3, ~bit_of(3)); tick();
    chk("R5", "sub masked", 32'(irq), 0);
    wr(3'd3, 32'hFFFF_FFFF);
    ssrc = '0; tick();

    // R8: sub edge bit 22
    cur_req = "R8";
    ssrc = bit_of(22); tick();
    ssrc = '0; tick();
    chk("R8", "sub edge held", 32'(vec), 55);
    rd(3'd4, d); chk("R8", "sub status readback", d, 32'h0040_0000);
    wr(3'd4, 32'h0); tick();
    chk("R8", "sub edge cleared", 32'(vec), 0);
    ssrc = bit_of(23); tick();
    chk("R8", "sub level bit23", 32'(vec), 56);
    ssrc = '0; tick();
    chk("R8", "sub level follows", 32'(vec), 0);

    // R11: status read-only, unmapped reads
    cur_req = "R11";
    wr(3'd1, 32'h0);
    rd(3'd0, d); chk("R11", "status write ignored", d, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R11", "unmapped read", d, 0);

    // R9: mask off suppresses irq
    cur_req = "R9";
    wr(3'd0, 32'h0);
    tsrc = bit_of(7); tick(); tick();
    chk("R9", "masked irq", 32'(irq), 0);
    tsrc = '0; tick();

    chk_en = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule